// File: doc/BRIEF.md
# RAID-6 Dual Parity Stripe Encoder

This block streams the data disks of one stripe offset through two accumulators and returns the two RAID-6 check words for that offset. The P word is the bitwise XOR of every data beat. The Q word is a Reed-Solomon syndrome over GF(2^8) with reduction polynomial 0x11d. Each byte lane of a beat is handled on its own, with no interaction between lanes.

Data beats are offered on a valid/ready input, one beat per data disk. The highest-numbered disk comes first and disk 0 comes last. A flag marks the first beat of an offset and another flag marks the final beat. After the final beat has been accepted, P and Q are offered together on a single valid/ready output beat. The input stalls until that beat has been taken. Once P and Q have been handed over, both accumulators return to zero, ready for the next offset. In a stripe of N slots, slots 0 to N-3 carry data, slot N-2 takes P and slot N-1 takes Q. Placing the results in those slots is left to the surrounding logic.

Top module: `pq_syndrome_gen`

## Requirements
- R1: While reset is asserted and just after it, `outValid` is 0, `inReady` is 1, `errFirstLast` is 0, and `outP` and `outQ` are all zeros.
- R2: `outP` equals the XOR of every data beat accepted for the offset.
- R3: `outQ` is built Horner-style. The first beat loads the accumulator. Each later beat first doubles the accumulator in GF(2^8) and then XORs itself in. Disk k therefore carries coefficient 2^k, and disk 0, sent last, carries coefficient 1.
- R4: Doubling acts on each byte lane independently. The byte is shifted left by one bit and the carry is dropped. If bit 7 of the byte was set before the shift, the result is XORed with 0x1d. No bit crosses a lane boundary.
- R5: `outValid` rises in the cycle after a beat with `inLast`=1 and `inFirst`=0 is accepted. `outP` and `outQ` hold steady while `outValid`=1 and `outReady`=0.
- R6: `inReady` is 0 whenever an output beat is pending.
- R7: Once an output beat is taken (`outValid` and `outReady` both 1 at an edge), `outValid` drops and `outP` and `outQ` read all zeros. The next offset then starts from cleared accumulators.
- R8: A beat accepted with both `inFirst`=1 and `inLast`=1 raises `errFirstLast` for exactly the following cycle. That beat is dropped: it produces no output beat and leaves both accumulators unchanged.
- R9: A beat with `inFirst`=1 and `inLast`=0 reloads both accumulators with its own data, which discards any partial result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A data beat is offered |
| inReady | output | 1 | The block can accept a data beat |
| inFirst | input | 1 | The beat is the highest-numbered data disk |
| inLast | input | 1 | The beat is disk 0, which closes the offset |
| inData | input | LANES*8 | Data beat, byte lane l in bits 8l+7..8l |
| outValid | output | 1 | P and Q are ready to be taken |
| outReady | input | 1 | The consumer takes P and Q |
| outP | output | LANES*8 | XOR parity word |
| outQ | output | LANES*8 | GF(2^8) syndrome word |
| errFirstLast | output | 1 | One-cycle pulse after a dropped first-and-last beat |

## Verification
The bench builds the block with LANES=4, so each beat is 32 bits wide. Hand-chosen words then cover lanes with bit 7 set next to lanes with it clear, all within one beat. At this width a single beat can hold 0x80 and 0xFF in adjacent lanes. That lets the bench see directly whether a reduction stays inside its own lane, and a carry leaking into the next lane shows up at once. Stripes of two, three and four disks cover the first-beat load, repeated doubling, and the final fold of disk 0.

// File: rtl/raidpq_pkg.sv
package raidpq_pkg;
  // Reduction constant for GF(2^8) doubling, x^8 = x^4+x^3+x^2+1.
  localparam logic [7:0] GF_POLY = 8'h1d;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;   // restart both accumulators with the beat
    logic fold;   // accumulate the beat
    logic clear;  // zero both accumulators
  } pqStrobe_t;
endpackage

// File: rtl/pq_datapath.sv
module pq_datapath
  import raidpq_pkg::*;
#(
  parameter int LANES = 64,
  localparam int W = LANES * 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  pqStrobe_t    strb,
  input  logic [W-1:0] inData,
  output logic [W-1:0] accP,
  output logic [W-1:0] accQ
);

  logic [W-1:0] qDoubled;

  // Branch-free per-lane doubling: the sign bit is replicated into a mask
  // that selects the reduction constant.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] laneByte;
    logic [7:0] signMask;
    assign laneByte = accQ[l*8 +: 8];
    assign signMask = {8{laneByte[7]}};
    assign qDoubled[l*8 +: 8] = {laneByte[6:0], 1'b0} ^ (signMask & GF_POLY);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strb.clear) begin
      accP <= '0;
      accQ <= '0;
    end else if (strb.load) begin
      accP <= inData;
      accQ <= inData;
    end else if (strb.fold) begin
      accP <= accP ^ inData;
      accQ <= qDoubled ^ inData;
    end
  end

  // R9
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load && !strb.clear |=> accQ == accP);

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clear |=> accP == '0 && accQ == '0);

endmodule

// File: rtl/pq_ctrl.sv
module pq_ctrl
  import raidpq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      inValid,
  input  logic      inFirst,
  input  logic      inLast,
  input  logic      outReady,
  output logic      inReady,
  output logic      outValid,
  output logic      errFirstLast,
  output pqStrobe_t strb
);

  logic accept;
  logic badBeat;
  logic closeBeat;

  assign inReady   = !outValid;
  assign accept    = inValid && inReady;
  assign badBeat   = accept && inFirst && inLast;
  assign closeBeat = accept && inLast && !inFirst;

  always_comb begin
    strb.load  = accept && inFirst && !inLast;
    strb.fold  = accept && !inFirst;
    strb.clear = outValid && outReady;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid     <= 1'b0;
      errFirstLast <= 1'b0;
    end else begin
      errFirstLast <= badBeat;
      if (closeBeat)
        outValid <= 1'b1;
      else if (outReady)
        outValid <= 1'b0;
    end
  end

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> outValid);

  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    errFirstLast |-> $past(inValid && inReady && inFirst && inLast));

endmodule

// File: rtl/pq_syndrome_gen.sv
module pq_syndrome_gen
  import raidpq_pkg::*;
#(
  parameter int LANES = 64,
  localparam int W = LANES * 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  output logic         inReady,
  input  logic         inFirst,
  input  logic         inLast,
  input  logic [W-1:0] inData,
  output logic         outValid,
  input  logic         outReady,
  output logic [W-1:0] outP,
  output logic [W-1:0] outQ,
  output logic         errFirstLast
);

  pqStrobe_t strb;

  pq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inFirst(inFirst),
    .inLast(inLast), .outReady(outReady), .inReady(inReady),
    .outValid(outValid), .errFirstLast(errFirstLast), .strb(strb)
  );

  pq_datapath #(.LANES(LANES)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .inData(inData),
    .accP(outP), .accQ(outQ)
  );

  // R5
  result_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> $stable(outP) && $stable(outQ));

  // R8
  drop_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && inReady && inFirst && inLast |=> !outValid && $stable(outP) && $stable(outQ));

  // R6
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inValid && inReady && inLast && !inFirst) |-> !inReady);

endmodule

// File: tb/pq_syndrome_gen_tb.sv
`timescale 1ns/1ps
module pq_syndrome_gen_tb;
  localparam int LANES = 4;
  localparam int W = LANES * 8;
  localparam int NV = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0, inFirst = 1'b0, inLast = 1'b0, outReady = 1'b0;
  logic [W-1:0] inData = '0;
  logic inReady, outValid, errFirstLast;
  logic [W-1:0] outP, outQ;

  int nTests = 0, nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pq_syndrome_gen #(.LANES(LANES)) u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .inFirst(inFirst), .inLast(inLast), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outP(outP), .outQ(outQ),
    .errFirstLast(errFirstLast)
  );

  // Stripe table: disk count, then disk words indexed by disk number.
  localparam int NDSK [NV] = '{2, 3, 4, 3, 2, 4};
  localparam logic [W-1:0] VDAT [NV][4] = '{
    '{32'h0000_0000, 32'h8040_01FF, 32'h0, 32'h0},
    '{32'h1234_5678, 32'h9ABC_DEF0, 32'h8080_8080, 32'h0},
    '{32'hFFFF_FFFF, 32'h0102_0408, 32'h7F80_C3A5, 32'hDEAD_BEEF},
    '{32'h0000_0001, 32'h0000_0000, 32'hFF00_FF00, 32'h0},
    '{32'hCAFE_F00D, 32'hCAFE_F00D, 32'h0, 32'h0},
    '{32'h0, 32'h0, 32'h0, 32'h0000_0080}
  };

  // Per-lane GF(2^8) doubling as stated in R4.
  function automatic logic [W-1:0] gfDbl(input logic [W-1:0] x);
    logic [W-1:0] r;
    for (int l = 0; l < LANES; l++) begin
      logic [7:0] b;
      b = x[l*8 +: 8];
      r[l*8 +: 8] = (b << 1) ^ (b[7] ? 8'h1d : 8'h00);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic beat(input logic [W-1:0] d, input logic f, input logic l);
    @(negedge clk);
    inValid = 1'b1; inData = d; inFirst = f; inLast = l;
    @(negedge clk);
    inValid = 1'b0; inFirst = 1'b0; inLast = 1'b0;
  endtask

  task automatic drain;
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
  endtask

  initial begin
    logic [W-1:0] eP, eQ;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 outValid", W'(outValid), '0);
    check("R1 inReady", W'(inReady), 1);
    check("R1 err", W'(errFirstLast), '0);
    check("R1 outP", outP, '0);
    check("R1 outQ", outQ, '0);
    rst_n = 1'b1;

    // Hand-computed: disk1 = 80_40_01_FF, disk0 = 0 -> Q lanes 1d_80_02_E3 (R4)
    beat(32'h8040_01FF, 1'b1, 1'b0);
    beat(32'h0000_0000, 1'b0, 1'b1);
    check("R5 outValid", W'(outValid), 1);
    check("R4 lane reduce", outQ, 32'h1d80_02E3);
    check("R2 P two disks", outP, 32'h8040_01FF);
    drain();

    // Table walk (R2, R3)
    for (int v = 0; v < NV; v++) begin
      eP = '0; eQ = '0;
      for (int k = NDSK[v] - 1; k >= 0; k--) begin
        eP = eP ^ VDAT[v][k];
        eQ = gfDbl(eQ) ^ VDAT[v][k];
        beat(VDAT[v][k], k == NDSK[v] - 1, k == 0);
      end
      check("R2 P", outP, eP);
      check("R3 Q", outQ, eQ);
      check("R6 inReady", W'(inReady), '0);
      @(negedge clk);
      check("R5 hold P", outP, eP);
      check("R5 hold Q", outQ, eQ);
      check("R5 hold valid", W'(outValid), 1);
      drain();
      check("R7 valid low", W'(outValid), '0);
      check("R7 P zero", outP, '0);
      check("R7 Q zero", outQ, '0);
    end

    // R8 lone first+last beat dropped
    beat(32'h5555_AAAA, 1'b1, 1'b1);
    check("R8 err pulse", W'(errFirstLast), 1);
    check("R8 no output", W'(outValid), '0);
    check("R8 P untouched", outP, '0);
    @(negedge clk);
    check("R8 err one cycle", W'(errFirstLast), '0);

    // R8 mid-stripe bad beat leaves partial state
    beat(32'h1111_2222, 1'b1, 1'b0);
    beat(32'hF0F0_F0F0, 1'b1, 1'b1);
    beat(32'h0F00_00F0, 1'b0, 1'b1);
    check("R8 mid P", outP, 32'h1111_2222 ^ 32'h0F00_00F0);
    check("R8 mid Q", outQ, gfDbl(32'h1111_2222) ^ 32'h0F00_00F0);
    drain();

    // R9 restart discards partial result
    beat(32'hAAAA_AAAA, 1'b1, 1'b0);
    beat(32'h9080_7060, 1'b1, 1'b0);
    beat(32'h0102_0304, 1'b0, 1'b1);
    check("R9 P", outP, 32'h9080_7060 ^ 32'h0102_0304);
    check("R9 Q", outQ, gfDbl(32'h9080_7060) ^ 32'h0102_0304);
    drain();

    // R1 reset clears a pending output
    beat(32'h1234_0000, 1'b1, 1'b0);
    beat(32'h0000_4321, 1'b0, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset valid", W'(outValid), '0);
    check("R1 reset P", outP, '0);
    check("R1 reset Q", outQ, '0);
    rst_n = 1'b1;

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nTests++; nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule